// File: doc/BRIEF.md
# Setup-Mode ASCII Command Parser

This block serves a radio modem's configuration mode. While the active-low setup input is held low, the radio link is switched off and the block takes characters from a UART receiver. It sends each character back to the UART transmitter and collects the printable ones into a short line buffer. When a carriage return arrives, the buffered line is compared with a small fixed command set. The commands set the working address and the working channel, save the address as the power-up default, and select a transmitter test mode.

The working address (three bits) and the working channel (0 to 4) are loaded from the stored default values at reset. A save command raises a write request to the non-volatile storage and holds it until the storage answers with an acknowledge. The block then sends a `~` character to report that the write is done. Releasing the setup input returns the block to normal use. The partly typed line is dropped and the test mode falls back to transmitter-off. The working address and channel keep their values.

Top module: `setup_cmd_parser`

## Requirements
- R1: `link_en` is low while `setup_n` is low and high while `setup_n` is high.
- R2: With `setup_n` low, a byte accepted on `rx_valid` appears on `tx_data` with `tx_valid` high in the next cycle. With `setup_n` high, received bytes are ignored and `tx_valid` stays low.
- R3: The line `ADDR` followed by one ASCII digit `0`..`7` and a carriage return (0x0D) sets `work_addr` to that digit.
- R4: The line `CHAN` followed by one ASCII digit `0`..`4` and a carriage return sets `work_chan` to that digit. `work_chan` never exceeds 4.
- R5: The line `SETPROGRAM` with a carriage return raises `nv_wr_req` in the next cycle, with `nv_wr_addr` equal to the current `work_addr`. The request and its address stay unchanged until a cycle in which `nv_wr_ack` is high, and the request drops after that cycle.
- R6: After the acknowledge, `~` (0x7E) is sent on `tx_data` in the first following cycle that carries no echo, provided setup is still held.
- R7: `NOTONE`, `LFTONE`, `HFTONE` and `#` set `tone_mode` to 1 (unmodulated carrier), 2 (8 kHz square), 3 (16 kHz square) and 0 (off), respectively.
- R8: A command acts only when the carriage return arrives. A line feed (0x0A) is echoed but not stored in the line.
- R9: A line that is not a command, or that has an out-of-range digit (for example `ADDR8` or `CHAN5`), leaves `work_addr`, `work_chan`, `tone_mode` and `nv_wr_req` unchanged.
- R10: A line of more than 12 stored characters is discarded at its carriage return, and the next line is parsed normally.
- R11: After reset, `work_addr` equals `dflt_addr`, `work_chan` equals `dflt_chan`, `tone_mode` is 0, and `tx_valid` and `nv_wr_req` are low.
- R12: While `setup_n` is high, `tone_mode` is forced to 0 and the partial line is cleared, so characters typed before a release never join characters typed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_n | input | 1 | Active-low setup mode select |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| dflt_addr | input | 3 | Stored default address, loaded at reset |
| dflt_chan | input | 3 | Stored default channel, loaded at reset |
| nv_wr_ack | input | 1 | Storage has finished the write |
| tx_valid | output | 1 | One-cycle strobe: a byte to transmit |
| tx_data | output | 8 | Byte to transmit (echo or `~`) |
| nv_wr_req | output | 1 | Write request to storage |
| nv_wr_addr | output | 3 | Address value to store |
| work_addr | output | 3 | Working address |
| work_chan | output | 3 | Working channel, 0..4 |
| link_en | output | 1 | Radio link enable |
| tone_mode | output | 2 | 0 off, 1 carrier, 2 low tone, 3 high tone |

## Verification
The properties assume that the stored default channel is within range. They also assume that the UART transmitter accepts every strobe, because the echo path has no back-pressure, and that `nv_wr_ack` is raised only while a request is pending. The stimulus drives at most one received byte every other cycle, which leaves an idle slot for the `~`. The defaults are fixed at legal values, and the acknowledge is pulsed for one cycle only after the bench has seen the request.

// File: rtl/setup_cmd_parser.sv
module setup_cmd_parser #(
  parameter int LINE_MAX  = 12,
  parameter int ADDR_W    = 3,
  parameter int CHAN_W    = 3,
  parameter int CHAN_LAST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic [ADDR_W-1:0] dflt_addr,
  input  logic [CHAN_W-1:0] dflt_chan,
  input  logic              nv_wr_ack,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              nv_wr_req,
  output logic [ADDR_W-1:0] nv_wr_addr,
  output logic [ADDR_W-1:0] work_addr,
  output logic [CHAN_W-1:0] work_chan,
  output logic              link_en,
  output logic [1:0]        tone_mode
);
  localparam int LW = $clog2(LINE_MAX + 1);
  localparam int LB = 8 * LINE_MAX;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_DONE = 8'h7E;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [1:0] T_OFF = 2'd0, T_CARR = 2'd1, T_LOW = 2'd2, T_HIGH = 2'd3;

  logic [LB-1:0] line;
  logic [LW-1:0] len;
  logic          ovf;
  logic          pend;

  wire active = ~setup_n;
  wire take   = active & rx_valid;
  wire is_cr  = (rx_data == CH_CR);
  wire is_lf  = (rx_data == CH_LF);
  wire exec   = take & is_cr & ~ovf;
  wire ack    = nv_wr_req & nv_wr_ack;

  wire [7:0] dig = line[7:0] - CH_ZERO;
  wire dig_ok = (line[7:0] >= CH_ZERO);

  wire m_addr = (len == LW'(5)) && (line[39:8] == "ADDR") && dig_ok && (dig < 8'(2 ** ADDR_W));
  wire m_chan = (len == LW'(5)) && (line[39:8] == "CHAN") && dig_ok && (dig <= 8'(CHAN_LAST));
  wire m_save = (len == LW'(10)) && (line[79:0] == "SETPROGRAM");
  wire m_carr = (len == LW'(6)) && (line[47:0] == "NOTONE");
  wire m_low  = (len == LW'(6)) && (line[47:0] == "LFTONE");
  wire m_high = (len == LW'(6)) && (line[47:0] == "HFTONE");
  wire m_off  = (len == LW'(1)) && (line[7:0] == "#");

  assign link_en = setup_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= '0;
      len  <= '0;
      ovf  <= 1'b0;
    end else if (!active || (take && is_cr)) begin
      line <= '0;
      len  <= '0;
      ovf  <= 1'b0;
    end else if (take && !is_lf) begin
      if (len == LW'(LINE_MAX)) begin
        ovf <= 1'b1;
      end else begin
        line <= {line[LB-9:0], rx_data};
        len  <= len + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      pend     <= 1'b0;
    end else begin
      if (take) begin
        tx_valid <= 1'b1;
        tx_data  <= rx_data;
      end else if (active && pend) begin
        tx_valid <= 1'b1;
        tx_data  <= CH_DONE;
      end else begin
        tx_valid <= 1'b0;
      end
      if (!active)          pend <= 1'b0;
      else if (ack)         pend <= 1'b1;
      else if (!take)       pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_addr  <= dflt_addr;
      work_chan  <= dflt_chan;
      tone_mode  <= T_OFF;
      nv_wr_req  <= 1'b0;
      nv_wr_addr <= '0;
    end else begin
      if (ack) begin
        nv_wr_req <= 1'b0;
      end else if (exec && m_save && !nv_wr_req) begin
        nv_wr_req  <= 1'b1;
        nv_wr_addr <= work_addr;
      end
      if (exec && m_addr) work_addr <= dig[ADDR_W-1:0];
      if (exec && m_chan) work_chan <= dig[CHAN_W-1:0];
      if (!active)                tone_mode <= T_OFF;
      else if (exec && m_carr)    tone_mode <= T_CARR;
      else if (exec && m_low)     tone_mode <= T_LOW;
      else if (exec && m_high)    tone_mode <= T_HIGH;
      else if (exec && m_off)     tone_mode <= T_OFF;
    end
  end
endmodule

// File: rtl/setup_cmd_parser_chk.sv
module setup_cmd_parser_chk #(
  parameter int ADDR_W    = 3,
  parameter int CHAN_W    = 3,
  parameter int CHAN_LAST = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              setup_n,
  input logic              rx_valid,
  input logic [7:0]        rx_data,
  input logic              nv_wr_ack,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              nv_wr_req,
  input logic [ADDR_W-1:0] nv_wr_addr,
  input logic [ADDR_W-1:0] work_addr,
  input logic [CHAN_W-1:0] work_chan,
  input logic [1:0]        tone_mode
);
  a_r2_echo_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_n && rx_valid) |=> (tx_valid && tx_data == $past(rx_data)));

  a_r2_silent_outside: assert property (@(posedge clk) disable iff (!rst_n)
    setup_n |=> !tx_valid);

  a_r4_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    work_chan <= CHAN_W'(CHAN_LAST));

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr_req && !nv_wr_ack) |=> (nv_wr_req && $stable(nv_wr_addr)));

  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr_req && nv_wr_ack) |=> !nv_wr_req);

  a_r8_no_cr_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(!setup_n && rx_valid && rx_data == 8'h0D) |=> ($stable(work_addr) && $stable(work_chan)));

  a_r12_tone_off_outside: assert property (@(posedge clk) disable iff (!rst_n)
    setup_n |=> (tone_mode == 2'd0));
endmodule

bind setup_cmd_parser setup_cmd_parser_chk #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .CHAN_LAST(CHAN_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_n(setup_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .nv_wr_ack(nv_wr_ack), .tx_valid(tx_valid), .tx_data(tx_data), .nv_wr_req(nv_wr_req),
  .nv_wr_addr(nv_wr_addr), .work_addr(work_addr), .work_chan(work_chan), .tone_mode(tone_mode)
);

// File: tb/tb_setup_cmd_parser.sv
`timescale 1ns/1ps
module tb_setup_cmd_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_n = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [2:0] dflt_addr = 3'd5;
  logic [2:0] dflt_chan = 3'd2;
  logic nv_wr_ack = 1'b0;
  logic tx_valid, nv_wr_req, link_en;
  logic [7:0] tx_data;
  logic [2:0] nv_wr_addr, work_addr, work_chan;
  logic [1:0] tone_mode;

  always #2.5 clk = ~clk;

  setup_cmd_parser dut (
    .clk(clk), .rst_n(rst_n), .setup_n(setup_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .dflt_addr(dflt_addr), .dflt_chan(dflt_chan), .nv_wr_ack(nv_wr_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .nv_wr_req(nv_wr_req), .nv_wr_addr(nv_wr_addr),
    .work_addr(work_addr), .work_chan(work_chan), .link_en(link_en), .tone_mode(tone_mode)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  byte q[$];
  bit  m_ovf, m_req, m_pend, m_txv;
  int  m_addr, m_chan, m_tone, m_waddr, m_txd;
  bit  m_live = 0;

  function automatic bit is_line(string s);
    if (q.size() != s.len()) return 0;
    for (int i = 0; i < s.len(); i++) if (q[i] != s[i]) return 0;
    return 1;
  endfunction

  function automatic int digit_of(string pre, int maxd);
    if (q.size() != 5) return -1;
    for (int i = 0; i < 4; i++) if (q[i] != pre[i]) return -1;
    if (q[4] < 8'h30 || q[4] > 8'h30 + maxd) return -1;
    return q[4] - 8'h30;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ovf = 0; m_req = 0; m_pend = 0; m_txv = 0; m_txd = 0;
      m_addr = dflt_addr; m_chan = dflt_chan; m_tone = 0; m_waddr = 0; m_live = 1;
    end else begin
      bit take, old_req, old_pend;
      int d;
      take = !setup_n && rx_valid;
      old_req = m_req; old_pend = m_pend;
      if (take) begin m_txv = 1; m_txd = rx_data; end
      else if (!setup_n && old_pend) begin m_txv = 1; m_txd = 126; end
      else m_txv = 0;
      if (setup_n) m_pend = 0;
      else if (old_req && nv_wr_ack) m_pend = 1;
      else if (!take) m_pend = 0;
      if (old_req && nv_wr_ack) m_req = 0;
      if (setup_n) begin
        q.delete(); m_ovf = 0; m_tone = 0;
      end else if (take) begin
        if (rx_data == 8'h0D) begin
          if (!m_ovf) begin
            d = digit_of("ADDR", 7); if (d >= 0) m_addr = d;
            d = digit_of("CHAN", 4); if (d >= 0) m_chan = d;
            if (is_line("SETPROGRAM") && !old_req) begin m_req = 1; m_waddr = m_addr; end
            if (is_line("NOTONE")) m_tone = 1;
            if (is_line("LFTONE")) m_tone = 2;
            if (is_line("HFTONE")) m_tone = 3;
            if (is_line("#")) m_tone = 0;
          end
          q.delete(); m_ovf = 0;
        end else if (rx_data != 8'h0A) begin
          if (q.size() == 12) m_ovf = 1; else q.push_back(rx_data);
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_live && rst_n && !done) begin
      check(link_en == setup_n, "R1 link_en", link_en, setup_n);
      check(tx_valid == m_txv, "R2 tx_valid", tx_valid, m_txv);
      if (m_txv) check(tx_data == 8'(m_txd), "R2/R6 tx_data", tx_data, m_txd);
      check(work_addr == 3'(m_addr), "R3 work_addr", work_addr, m_addr);
      check(work_chan == 3'(m_chan), "R4 work_chan", work_chan, m_chan);
      check(nv_wr_req == m_req, "R5 nv_wr_req", nv_wr_req, m_req);
      if (m_req) check(nv_wr_addr == 3'(m_waddr), "R5 nv_wr_addr", nv_wr_addr, m_waddr);
      check(tone_mode == 2'(m_tone), "R7 tone_mode", tone_mode, m_tone);
    end
  end

  task automatic send(string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = s[i];
      @(negedge clk); rx_valid = 1'b0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(work_addr == 3'd5, "R11 reset addr", work_addr, 5);
    check(work_chan == 3'd2, "R11 reset chan", work_chan, 2);
    check(tone_mode == 2'd0 && !tx_valid && !nv_wr_req, "R11 reset outputs", tone_mode, 0);
    check(link_en == 1'b1, "R1 link on", link_en, 1);

    send("A");
    check(!tx_valid, "R2 no echo outside setup", tx_valid, 0);

    setup_n = 1'b0; idle(2);
    check(link_en == 1'b0, "R1 link off", link_en, 0);
    send("ADDR3\r\n");
    check(work_addr == 3'd3, "R3 ADDR3", work_addr, 3);
    send("ADDR8\r");
    check(work_addr == 3'd3, "R9 ADDR8 ignored", work_addr, 3);
    send("CHAN4\r");
    check(work_chan == 3'd4, "R4 CHAN4", work_chan, 4);
    send("CHAN5\r");
    check(work_chan == 3'd4, "R9 CHAN5 ignored", work_chan, 4);
    send("FOO\r");
    check(work_chan == 3'd4 && work_addr == 3'd3, "R9 unknown", work_chan, 4);
    send("CHA\nN1\r");
    check(work_chan == 3'd1, "R8 LF ignored", work_chan, 1);
    send("CHAN0");
    check(work_chan == 3'd1, "R8 waits for CR", work_chan, 1);
    send("\r");
    check(work_chan == 3'd0, "R8 CR executes", work_chan, 0);

    send("LFTONE\r");
    check(tone_mode == 2'd2, "R7 LFTONE", tone_mode, 2);
    send("HFTONE\r");
    check(tone_mode == 2'd3, "R7 HFTONE", tone_mode, 3);
    send("NOTONE\r");
    check(tone_mode == 2'd1, "R7 NOTONE", tone_mode, 1);
    send("#\r");
    check(tone_mode == 2'd0, "R7 off", tone_mode, 0);

    send("XXXXXXXXXCHAN2\r");
    check(work_chan == 3'd0, "R10 long line dropped", work_chan, 0);
    send("CHAN3\r");
    check(work_chan == 3'd3, "R10 next line parsed", work_chan, 3);

    send("HFTONE\r");
    send("ADD");
    setup_n = 1'b1; idle(2);
    check(tone_mode == 2'd0, "R12 tone forced off", tone_mode, 0);
    setup_n = 1'b0; idle(2);
    send("R6\r");
    check(work_addr == 3'd3, "R12 partial line cleared", work_addr, 3);

    send("ADDR6\r");
    send("SETPROGRAM\r");
    check(nv_wr_req && nv_wr_addr == 3'd6, "R5 request raised", nv_wr_addr, 6);
    idle(4);
    check(nv_wr_req == 1'b1, "R5 request held", nv_wr_req, 1);
    @(negedge clk); nv_wr_ack = 1'b1;
    @(negedge clk); nv_wr_ack = 1'b0;
    check(!nv_wr_req, "R5 request dropped", nv_wr_req, 0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      if (tx_valid && tx_data == 8'h7E) seen = 1;
      @(negedge clk);
    end
    check(seen, "R6 tilde sent", seen, 1);
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule